// File: doc/BRIEF.md
# ATA Host Register Bank with Timing Selection

This block is the register bank of an ATA/IDE host controller on a 32-bit memory-mapped bus. It stores the controller's control word, an interrupt status flag, the command-cycle PIO timing, a fast PIO timing word for each of the two attached devices, two DMA timing words, and a transmit buffer word. It returns a receive buffer word supplied by the DMA side. Accesses with address bit 7 set hit these host registers. Accesses with address bit 7 clear go to the attached device through a simple request/acknowledge port that carries the low 7 address bits.

For each device access, the block latches the timing word that the external bus-cycle generator must apply. Data-register transfers use the fast timing of the device picked by the last device/head write. Every other device access uses the command timing. The device hardware reset line follows a bit of the control word. A build-time variant (1, 2 or 3) decides whether the fast PIO timing words and the DMA/buffer words exist.

Top module: `ata_regbank`

## Requirements
- R1: After reset, the control word reads 0x00000001 and dev_hw_reset is 1. The status word reads variant in bits 31:28, revision in bits 27:24 and 0 elsewhere. The command timing and both fast timing words read 0x17021C06 (T1=6 in bits 7:0, T2=28 in bits 15:8, T4=2 in bits 23:16, Teoc=23 in bits 31:24). Both DMA words read 0x15001504 (Tm=4 in bits 7:0, Td=21 in bits 15:8, Teoc=21 in bits 31:24). tx_data is 0 and timing_word equals the command timing.
- R2: The host registers sit at byte offsets 0x80 control, 0x84 status, 0x88 command timing, 0x8C fast timing device 0, 0x90 fast timing device 1, 0x94/0x98 DMA timing 0/1, and 0x9C buffer. The fast timing words read 0 unless the variant is above 1. The DMA words and the receive buffer read 0 unless the variant is above 2.
- R3: Any other host offset in 0x80..0xFC reads 0, and a write to it changes no register.
- R4: Status bit 0 is the interrupt flag. A dev_intrq pulse sets it. A status write ANDs the flag with write bit 0, so writing 0 clears it and writing 1 keeps it. No other status bit can be written.
- R5: After a control write, dev_hw_reset equals bit 0 of the written value, from the next cycle on.
- R6: Control bit 7 is the IDE enable. With it set, a device access raises dev_req with the access's write flag, 7-bit offset and data, and a read returns dev_rdata. With it clear, no dev_req is raised, a read returns 0 and a write is dropped.
- R7: On variants above 1, a device access at offset 0x10 (data register) latches fast timing device 1 into timing_word if the selected device is 1, and fast timing device 0 if it is 0. On variant 1 it latches the command timing.
- R8: Every other device access latches the command timing into timing_word. Host accesses and disabled device accesses leave timing_word unchanged.
- R9: A device write at offset 0x16 (device/head) stores its bit 4 as the selected device (reset value 0) and is forwarded to the device port.
- R10: A host access, or a disabled device access, presented in cycle c gets resp_valid in cycle c+2. Requests that arrive while busy is high are ignored.
- R11: A write to 0x9C drives its value on tx_data. A read of 0x9C returns rx_data on variant 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Access request, accepted when busy is low |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 8 | Byte address; bit 7 selects the host registers |
| req_wdata | input | 32 | Write data |
| busy | output | 1 | An access is in progress |
| resp_valid | output | 1 | One-cycle response strobe |
| resp_rdata | output | 32 | Read data, valid with resp_valid |
| dev_req | output | 1 | Device access request |
| dev_write | output | 1 | Device access direction |
| dev_addr | output | 7 | Device register offset |
| dev_wdata | output | 32 | Device write data |
| dev_ack | input | 1 | Device access complete |
| dev_rdata | input | 32 | Device read data, valid with dev_ack |
| dev_intrq | input | 1 | Device interrupt event |
| rx_data | input | 32 | Receive buffer word |
| tx_data | output | 32 | Transmit buffer word |
| timing_word | output | 32 | Timing word for the current device access |
| dev_hw_reset | output | 1 | Device hardware reset |

## Verification
The assertions check, on every cycle, several rules: how dev_hw_reset tracks control writes, that dev_req never starts while the enable is clear, that the interrupt flag only rises after a dev_intrq event, the two-cycle host response shape, and that timing_word only moves after an accepted enabled device access. Other behaviours need the bench's scenarios. These are the reset values and variant gating of every host offset, the choice between the two fast timing words after device/head writes, clear-only behaviour of status writes, forwarding of device data, and requests dropped while busy. Two variants are compared side by side under the same stimulus.

// File: rtl/ata_regbank_pkg.sv
package ata_regbank_pkg;

    localparam int WORD_W   = 32;
    localparam int FIELD_W  = 8;
    localparam int ADDR_W   = 8;
    localparam int DOFS_W   = ADDR_W - 1;
    localparam int HIDX_W   = ADDR_W - 3;
    localparam int NFAST    = 2;
    localparam int NDMA     = 2;

    // host register word indices (address bits 6:2)
    localparam logic [HIDX_W-1:0] HIDX_CTRL  = 5'd0;
    localparam logic [HIDX_W-1:0] HIDX_STAT  = 5'd1;
    localparam logic [HIDX_W-1:0] HIDX_PIO   = 5'd2;
    localparam logic [HIDX_W-1:0] HIDX_FAST0 = 5'd3;
    localparam logic [HIDX_W-1:0] HIDX_DMA0  = 5'd5;
    localparam logic [HIDX_W-1:0] HIDX_XBUF  = 5'd7;

    localparam int CTRL_RST_BIT = 0;
    localparam int CTRL_EN_BIT  = 7;
    localparam int HEAD_DEV_BIT = 4;

    localparam logic [DOFS_W-1:0] DOFS_DATA = 7'h10;
    localparam logic [DOFS_W-1:0] DOFS_HEAD = 7'h16;

    typedef enum logic [1:0] {
        XS_IDLE,
        XS_HWAIT,
        XS_DEV,
        XS_RESP
    } xfer_st_t;

    function automatic logic [WORD_W-1:0] pack_pio(input int t1, input int t2,
                                                   input int t4, input int teoc);
        return {FIELD_W'(teoc), FIELD_W'(t4), FIELD_W'(t2), FIELD_W'(t1)};
    endfunction

    function automatic logic [WORD_W-1:0] pack_dma(input int tm, input int td,
                                                   input int teoc);
        return {FIELD_W'(teoc), FIELD_W'(0), FIELD_W'(td), FIELD_W'(tm)};
    endfunction

endpackage

// File: rtl/ata_hreg_file.sv
module ata_hreg_file
    import ata_regbank_pkg::*;
#(
    parameter int                VARIANT  = 3,
    parameter int                REVISION = 1,
    parameter logic [WORD_W-1:0] PIO_RST  = '0,
    parameter logic [WORD_W-1:0] DMA_RST  = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [HIDX_W-1:0] idx,
    input  logic [WORD_W-1:0] wdata,
    input  logic              dev_intrq,
    input  logic [WORD_W-1:0] rx_data,
    output logic [WORD_W-1:0] rd_data,
    output logic [WORD_W-1:0] ctrl,
    output logic [WORD_W-1:0] pio_word,
    output logic [WORD_W-1:0] fast0,
    output logic [WORD_W-1:0] fast1,
    output logic [WORD_W-1:0] tx_data,
    output logic              irq_flag
);

    localparam bit HAS_FAST = (VARIANT > 1);
    localparam bit HAS_DMA  = (VARIANT > 2);
    localparam int STAT_PAD = WORD_W - 9;

    typedef struct packed {
        logic [WORD_W-1:0] ctrl;
        logic              irq;
        logic [WORD_W-1:0] pio;
        logic [WORD_W-1:0] tx;
    } core_t;

    core_t r_d, r_q;

    logic [NFAST-1:0][WORD_W-1:0] fast_q;
    logic [NDMA-1:0][WORD_W-1:0]  dma_q;

    always_comb begin
        r_d = r_q;
        if (wr_en) begin
            case (idx)
                HIDX_CTRL: r_d.ctrl = wdata;
                HIDX_STAT: r_d.irq  = r_q.irq & wdata[0];
                HIDX_PIO:  r_d.pio  = wdata;
                HIDX_XBUF: r_d.tx   = wdata;
                default:   ;
            endcase
        end
        if (dev_intrq) r_d.irq = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{ctrl: WORD_W'(1), irq: 1'b0, pio: PIO_RST, tx: '0};
        else        r_q <= r_d;
    end

    generate
        if (HAS_FAST) begin : g_fast
            for (genvar i = 0; i < NFAST; i++) begin : g_dev
                logic [WORD_W-1:0] word_d, word_q;
                always_comb begin
                    word_d = word_q;
                    if (wr_en && idx == HIDX_FAST0 + HIDX_W'(i)) word_d = wdata;
                end
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) word_q <= PIO_RST;
                    else        word_q <= word_d;
                end
                assign fast_q[i] = word_q;
            end
        end else begin : g_nofast
            assign fast_q = '0;
        end

        if (HAS_DMA) begin : g_dma
            for (genvar i = 0; i < NDMA; i++) begin : g_ch
                logic [WORD_W-1:0] word_d, word_q;
                always_comb begin
                    word_d = word_q;
                    if (wr_en && idx == HIDX_DMA0 + HIDX_W'(i)) word_d = wdata;
                end
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) word_q <= DMA_RST;
                    else        word_q <= word_d;
                end
                assign dma_q[i] = word_q;
            end
        end else begin : g_nodma
            assign dma_q = '0;
        end
    endgenerate

    always_comb begin
        rd_data = '0;
        case (idx)
            HIDX_CTRL:               rd_data = r_q.ctrl;
            HIDX_STAT:               rd_data = {4'(VARIANT), 4'(REVISION),
                                                STAT_PAD'(0), r_q.irq};
            HIDX_PIO:                rd_data = r_q.pio;
            HIDX_FAST0:              rd_data = fast_q[0];
            HIDX_FAST0 + 5'd1:       rd_data = fast_q[1];
            HIDX_DMA0:               rd_data = dma_q[0];
            HIDX_DMA0 + 5'd1:        rd_data = dma_q[1];
            HIDX_XBUF:               rd_data = HAS_DMA ? rx_data : '0;
            default:                 rd_data = '0;
        endcase
    end

    assign ctrl     = r_q.ctrl;
    assign pio_word = r_q.pio;
    assign fast0    = fast_q[0];
    assign fast1    = fast_q[1];
    assign tx_data  = r_q.tx;
    assign irq_flag = r_q.irq;

endmodule

// File: rtl/ata_timing_pick.sv
module ata_timing_pick
    import ata_regbank_pkg::*;
#(
    parameter int VARIANT = 3
) (
    input  logic              is_data,
    input  logic              sel_dev1,
    input  logic [WORD_W-1:0] pio_word,
    input  logic [WORD_W-1:0] fast0,
    input  logic [WORD_W-1:0] fast1,
    output logic [WORD_W-1:0] word
);

    generate
        if (VARIANT > 1) begin : g_split
            always_comb begin
                if (!is_data)     word = pio_word;
                else if (sel_dev1) word = fast1;
                else              word = fast0;
            end
        end else begin : g_single
            logic unused_sel;
            assign unused_sel = is_data ^ sel_dev1 ^ (^fast0) ^ (^fast1);
            assign word       = pio_word;
        end
    endgenerate

endmodule

// File: rtl/ata_xfer_ctl.sv
module ata_xfer_ctl
    import ata_regbank_pkg::*;
#(
    parameter logic [WORD_W-1:0] PIO_RST = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [WORD_W-1:0] req_wdata,
    input  logic [WORD_W-1:0] host_rdata,
    input  logic              ide_en,
    input  logic [WORD_W-1:0] pick_word,
    input  logic              dev_ack,
    input  logic [WORD_W-1:0] dev_rdata,
    output logic              host_wr_en,
    output logic [HIDX_W-1:0] host_idx,
    output logic              is_data,
    output logic              sel_dev1,
    output logic              busy,
    output logic              resp_valid,
    output logic [WORD_W-1:0] resp_rdata,
    output logic              dev_req,
    output logic              dev_write,
    output logic [DOFS_W-1:0] dev_addr,
    output logic [WORD_W-1:0] dev_wdata,
    output logic [WORD_W-1:0] timing_word
);

    typedef struct packed {
        xfer_st_t          st;
        logic [WORD_W-1:0] rdata;
        logic              dsel;
        logic              dwe;
        logic [DOFS_W-1:0] daddr;
        logic [WORD_W-1:0] dwdata;
        logic [WORD_W-1:0] timing;
    } xs_t;

    xs_t s_d, s_q;

    logic accept, to_host;

    assign accept     = req_valid && (s_q.st == XS_IDLE);
    assign to_host    = req_addr[ADDR_W-1];
    assign host_wr_en = accept && to_host && req_write;
    assign host_idx   = req_addr[ADDR_W-2:2];
    assign is_data    = (req_addr[DOFS_W-1:0] == DOFS_DATA);
    assign sel_dev1   = s_q.dsel;

    always_comb begin
        s_d = s_q;
        case (s_q.st)
            XS_IDLE: begin
                if (accept) begin
                    if (to_host) begin
                        s_d.st    = XS_HWAIT;
                        s_d.rdata = req_write ? '0 : host_rdata;
                    end else if (ide_en) begin
                        s_d.st     = XS_DEV;
                        s_d.dwe    = req_write;
                        s_d.daddr  = req_addr[DOFS_W-1:0];
                        s_d.dwdata = req_wdata;
                        s_d.timing = pick_word;
                        if (req_write && req_addr[DOFS_W-1:0] == DOFS_HEAD)
                            s_d.dsel = req_wdata[HEAD_DEV_BIT];
                    end else begin
                        s_d.st    = XS_HWAIT;
                        s_d.rdata = '0;
                    end
                end
            end
            XS_HWAIT: s_d.st = XS_RESP;
            XS_DEV: begin
                if (dev_ack) begin
                    s_d.st    = XS_RESP;
                    s_d.rdata = s_q.dwe ? '0 : dev_rdata;
                end
            end
            XS_RESP: s_d.st = XS_IDLE;
            default: s_d.st = XS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{st: XS_IDLE, rdata: '0, dsel: 1'b0, dwe: 1'b0,
                     daddr: '0, dwdata: '0, timing: PIO_RST};
        end else begin
            s_q <= s_d;
        end
    end

    assign busy        = (s_q.st != XS_IDLE);
    assign resp_valid  = (s_q.st == XS_RESP);
    assign resp_rdata  = s_q.rdata;
    assign dev_req     = (s_q.st == XS_DEV);
    assign dev_write   = s_q.dwe;
    assign dev_addr    = s_q.daddr;
    assign dev_wdata   = s_q.dwdata;
    assign timing_word = s_q.timing;

endmodule

// File: rtl/ata_regbank.sv
module ata_regbank
    import ata_regbank_pkg::*;
#(
    parameter int VARIANT   = 3,
    parameter int REVISION  = 1,
    parameter int PIO_T1    = 6,
    parameter int PIO_T2    = 28,
    parameter int PIO_T4    = 2,
    parameter int PIO_TEOC  = 23,
    parameter int DMA_TM    = 4,
    parameter int DMA_TD    = 21,
    parameter int DMA_TEOC  = 21
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [WORD_W-1:0] req_wdata,
    output logic              busy,
    output logic              resp_valid,
    output logic [WORD_W-1:0] resp_rdata,
    output logic              dev_req,
    output logic              dev_write,
    output logic [DOFS_W-1:0] dev_addr,
    output logic [WORD_W-1:0] dev_wdata,
    input  logic              dev_ack,
    input  logic [WORD_W-1:0] dev_rdata,
    input  logic              dev_intrq,
    input  logic [WORD_W-1:0] rx_data,
    output logic [WORD_W-1:0] tx_data,
    output logic [WORD_W-1:0] timing_word,
    output logic              dev_hw_reset
);

    localparam logic [WORD_W-1:0] PIO_RST = pack_pio(PIO_T1, PIO_T2, PIO_T4, PIO_TEOC);
    localparam logic [WORD_W-1:0] DMA_RST = pack_dma(DMA_TM, DMA_TD, DMA_TEOC);

    logic              host_wr_en;
    logic [HIDX_W-1:0] host_idx;
    logic [WORD_W-1:0] host_rdata;
    logic [WORD_W-1:0] ctrl;
    logic [WORD_W-1:0] pio_word, fast0, fast1;
    logic [WORD_W-1:0] pick_word;
    logic              is_data, sel_dev1;
    logic              irq_flag;
    logic              ide_en;

    ata_hreg_file #(
        .VARIANT (VARIANT),
        .REVISION(REVISION),
        .PIO_RST (PIO_RST),
        .DMA_RST (DMA_RST)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (host_wr_en),
        .idx      (host_idx),
        .wdata    (req_wdata),
        .dev_intrq(dev_intrq),
        .rx_data  (rx_data),
        .rd_data  (host_rdata),
        .ctrl     (ctrl),
        .pio_word (pio_word),
        .fast0    (fast0),
        .fast1    (fast1),
        .tx_data  (tx_data),
        .irq_flag (irq_flag)
    );

    ata_timing_pick #(
        .VARIANT(VARIANT)
    ) u_pick (
        .is_data (is_data),
        .sel_dev1(sel_dev1),
        .pio_word(pio_word),
        .fast0   (fast0),
        .fast1   (fast1),
        .word    (pick_word)
    );

    ata_xfer_ctl #(
        .PIO_RST(PIO_RST)
    ) u_xfer (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_write  (req_write),
        .req_addr   (req_addr),
        .req_wdata  (req_wdata),
        .host_rdata (host_rdata),
        .ide_en     (ide_en),
        .pick_word  (pick_word),
        .dev_ack    (dev_ack),
        .dev_rdata  (dev_rdata),
        .host_wr_en (host_wr_en),
        .host_idx   (host_idx),
        .is_data    (is_data),
        .sel_dev1   (sel_dev1),
        .busy       (busy),
        .resp_valid (resp_valid),
        .resp_rdata (resp_rdata),
        .dev_req    (dev_req),
        .dev_write  (dev_write),
        .dev_addr   (dev_addr),
        .dev_wdata  (dev_wdata),
        .timing_word(timing_word)
    );

    assign ide_en       = ctrl[CTRL_EN_BIT];
    assign dev_hw_reset = ctrl[CTRL_RST_BIT];

endmodule

// File: rtl/ata_regbank_chk.sv
module ata_regbank_chk
    import ata_regbank_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_write,
    input logic [ADDR_W-1:0] req_addr,
    input logic [WORD_W-1:0] req_wdata,
    input logic              busy,
    input logic              resp_valid,
    input logic              dev_req,
    input logic              dev_ack,
    input logic              dev_intrq,
    input logic              dev_hw_reset,
    input logic [WORD_W-1:0] timing_word,
    input logic              irq_flag,
    input logic              ide_en
);

    logic take, take_host, take_dev_on, take_dev_off, take_ctrl_wr;

    assign take         = req_valid && !busy;
    assign take_host    = take && req_addr[ADDR_W-1];
    assign take_dev_on  = take && !req_addr[ADDR_W-1] && ide_en;
    assign take_dev_off = take && !req_addr[ADDR_W-1] && !ide_en;
    assign take_ctrl_wr = take_host && req_write && (req_addr[ADDR_W-2:2] == HIDX_CTRL);

    a_r5_reset_follows_ctrl: assert property (@(posedge clk) disable iff (!rst_n)
        take_ctrl_wr |=> (dev_hw_reset == $past(req_wdata[CTRL_RST_BIT])));

    a_r6_no_dev_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        take_dev_off |=> !dev_req);

    a_r4_irq_rises_on_event: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_flag) |-> $past(dev_intrq));

    a_r10_host_two_cycles: assert property (@(posedge clk) disable iff (!rst_n)
        take_host |=> (busy && !resp_valid) ##1 resp_valid);

    a_r10_resp_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |-> busy);

    a_r8_timing_moves_on_dev: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(timing_word) |-> $past(take_dev_on));

    a_r6_dev_req_ends_on_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (dev_req && dev_ack) |=> !dev_req);

endmodule

bind ata_regbank ata_regbank_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_write   (req_write),
    .req_addr    (req_addr),
    .req_wdata   (req_wdata),
    .busy        (busy),
    .resp_valid  (resp_valid),
    .dev_req     (dev_req),
    .dev_ack     (dev_ack),
    .dev_intrq   (dev_intrq),
    .dev_hw_reset(dev_hw_reset),
    .timing_word (timing_word),
    .irq_flag    (irq_flag),
    .ide_en      (ide_en)
);

// File: tb/sim_ata_regbank.sv
module sim_ata_regbank;

    localparam logic [31:0] PIO_RST = 32'h17021C06;
    localparam logic [31:0] DMA_RST = 32'h15001504;
    localparam logic [31:0] RX_VAL  = 32'hCAFEF00D;
    localparam int          REV     = 1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [7:0]  req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic        dev_intrq = 1'b0;

    logic        busy0, rv0, dreq0, dwe0, hrst0;
    logic [31:0] rd0, dwd0, tx0, tw0, drd0;
    logic [6:0]  dad0;
    logic        busy1, rv1, dreq1, dwe1, hrst1;
    logic [31:0] rd1, dwd1, tx1, tw1, drd1;
    logic [6:0]  dad1;

    int checks = 0, fails = 0;
    int dev_cnt = 0;
    logic        last_we;
    logic [6:0]  last_addr;
    logic [31:0] last_wd;

    always #5 clk = ~clk;

    assign drd0 = 32'h0BAD0000 | {25'd0, dad0};
    assign drd1 = 32'h0BAD0000 | {25'd0, dad1};

    ata_regbank #(.VARIANT(3), .REVISION(REV)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .busy(busy0), .resp_valid(rv0),
        .resp_rdata(rd0), .dev_req(dreq0), .dev_write(dwe0), .dev_addr(dad0),
        .dev_wdata(dwd0), .dev_ack(dreq0), .dev_rdata(drd0), .dev_intrq(dev_intrq),
        .rx_data(RX_VAL), .tx_data(tx0), .timing_word(tw0), .dev_hw_reset(hrst0));

    ata_regbank #(.VARIANT(1), .REVISION(REV)) u1 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .busy(busy1), .resp_valid(rv1),
        .resp_rdata(rd1), .dev_req(dreq1), .dev_write(dwe1), .dev_addr(dad1),
        .dev_wdata(dwd1), .dev_ack(dreq1), .dev_rdata(drd1), .dev_intrq(dev_intrq),
        .rx_data(RX_VAL), .tx_data(tx1), .timing_word(tw1), .dev_hw_reset(hrst1));

    always @(posedge clk) begin
        if (dreq0) begin
            dev_cnt   <= dev_cnt + 1;
            last_we   <= dwe0;
            last_addr <= dad0;
            last_wd   <= dwd0;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic access(input logic w, input logic [7:0] a, input logic [31:0] d,
                          output logic [31:0] r0, output logic [31:0] r1, output int lat);
        @(negedge clk);
        req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0;
        lat = 1;
        while (!rv0 && lat < 50) begin
            @(negedge clk);
            lat++;
        end
        r0 = rd0;
        r1 = rd1;
        @(negedge clk);
    endtask

    function automatic logic [31:0] exp_reset(input int idx, input int variant);
        case (idx)
            0: return 32'h1;
            1: return {4'(variant), 4'(REV), 24'h0};
            2: return PIO_RST;
            3, 4: return (variant > 1) ? PIO_RST : 32'h0;
            5, 6: return (variant > 2) ? DMA_RST : 32'h0;
            7: return (variant > 2) ? RX_VAL : 32'h0;
            default: return 32'h0;
        endcase
    endfunction

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual hung expected done");
        $display("  [TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] r0, r1;
        int lat;
        int cnt_before;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state at the ports
        check("R1 hw reset", {31'd0, hrst0}, 32'd1);
        check("R1 timing", tw0, PIO_RST);
        check("R1 tx", tx0, 32'd0);
        check("R1 busy", {30'd0, busy0, rv0}, 32'd0);

        // R1 R2 R3 sweep of every host word on both variants
        for (int i = 0; i < 32; i++) begin
            access(1'b0, {1'b1, 5'(i), 2'b00}, 32'h0, r0, r1, lat);
            check($sformatf("R2 v3 read idx %0d", i), r0, exp_reset(i, 3));
            check($sformatf("R2 v1 read idx %0d", i), r1, exp_reset(i, 1));
        end

        // R10 latency of a host read
        access(1'b0, 8'h80, 32'h0, r0, r1, lat);
        check("R10 host latency", 32'(lat), 32'd2);

        // R10 requests during busy ignored; R5 reset line follows write
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = 8'h80; req_wdata = 32'h80;
        @(negedge clk);
        req_wdata = 32'h81;
        @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        @(negedge clk);
        check("R10 busy request ignored", {31'd0, hrst0}, 32'd0);
        access(1'b0, 8'h80, 32'h0, r0, r1, lat);
        check("R10 ctrl after ignored write", r0, 32'h80);

        // R5 toggling reset bit
        access(1'b1, 8'h80, 32'h81, r0, r1, lat);
        check("R5 reset set", {31'd0, hrst0}, 32'd1);
        access(1'b1, 8'h80, 32'h80, r0, r1, lat);
        check("R5 reset clear", {31'd0, hrst0}, 32'd0);

        // timing words
        access(1'b1, 8'h88, 32'h11223344, r0, r1, lat);
        access(1'b1, 8'h8C, 32'hAABBCC01, r0, r1, lat);
        access(1'b1, 8'h90, 32'h55667702, r0, r1, lat);
        access(1'b0, 8'h8C, 32'h0, r0, r1, lat);
        check("R2 fast0 readback v3", r0, 32'hAABBCC01);
        check("R2 fast0 absent v1", r1, 32'h0);

        // R9 device/head write selects device 1 and is forwarded
        access(1'b1, 8'h16, 32'h10, r0, r1, lat);
        check("R9 forwarded addr", {25'd0, last_addr}, 32'h16);
        check("R9 forwarded data", last_wd, 32'h10);
        check("R9 forwarded dir", {31'd0, last_we}, 32'd1);
        check("R8 head uses command timing", tw0, 32'h11223344);

        // R7 data register timing by selected device
        access(1'b0, 8'h10, 32'h0, r0, r1, lat);
        check("R6 device read data", r0, 32'h0BAD0010);
        check("R7 dev1 fast timing", tw0, 32'h55667702);
        check("R7 v1 command timing", tw1, 32'h11223344);

        access(1'b1, 8'h16, 32'hEF, r0, r1, lat);
        access(1'b0, 8'h10, 32'h0, r0, r1, lat);
        check("R7 dev0 fast timing", tw0, 32'hAABBCC01);

        access(1'b0, 8'h17, 32'h0, r0, r1, lat);
        check("R8 other offset timing", tw0, 32'h11223344);
        check("R6 device read other", r0, 32'h0BAD0017);

        // R6 disabled device access
        access(1'b1, 8'h80, 32'h0, r0, r1, lat);
        cnt_before = dev_cnt;
        access(1'b0, 8'h10, 32'h0, r0, r1, lat);
        check("R6 disabled read zero", r0, 32'h0);
        check("R6 disabled no request", 32'(dev_cnt), 32'(cnt_before));
        check("R10 disabled latency", 32'(lat), 32'd2);
        check("R8 disabled keeps timing", tw0, 32'h11223344);
        access(1'b1, 8'h10, 32'h1234, r0, r1, lat);
        check("R6 disabled write dropped", 32'(dev_cnt), 32'(cnt_before));

        // R4 interrupt flag
        @(negedge clk);
        dev_intrq = 1'b1;
        @(negedge clk);
        dev_intrq = 1'b0;
        access(1'b0, 8'h84, 32'h0, r0, r1, lat);
        check("R4 irq set v3", r0, 32'h31000001);
        check("R4 irq set v1", r1, 32'h11000001);
        access(1'b1, 8'h84, 32'hFFFFFFFF, r0, r1, lat);
        access(1'b0, 8'h84, 32'h0, r0, r1, lat);
        check("R4 write one keeps", r0, 32'h31000001);
        access(1'b1, 8'h84, 32'h0, r0, r1, lat);
        access(1'b0, 8'h84, 32'h0, r0, r1, lat);
        check("R4 write zero clears", r0, 32'h31000000);
        access(1'b1, 8'h84, 32'h1, r0, r1, lat);
        access(1'b0, 8'h84, 32'h0, r0, r1, lat);
        check("R4 write cannot set", r0, 32'h31000000);

        // R11 buffers
        access(1'b1, 8'h9C, 32'h12345678, r0, r1, lat);
        check("R11 tx out", tx0, 32'h12345678);
        access(1'b0, 8'h9C, 32'h0, r0, r1, lat);
        check("R11 rx read v3", r0, RX_VAL);
        check("R11 rx absent v1", r1, 32'h0);

        // R3 unknown offset
        access(1'b1, 8'hA0, 32'hFFFFFFFF, r0, r1, lat);
        access(1'b0, 8'hA0, 32'h0, r0, r1, lat);
        check("R3 unknown reads zero", r0, 32'h0);
        access(1'b0, 8'h80, 32'h0, r0, r1, lat);
        check("R3 ctrl untouched", r0, 32'h0);
        check("R3 reset line untouched", {31'd0, hrst0}, 32'd0);

        $display("  [TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end

endmodule